// File: doc/BRIEF.md
# SMBus Clock Timeout Monitor

This block watches the synchronized SCL and SDA lines of an SMBus port and raises sticky flags when bus timing limits are broken. It runs from the kernel clock and holds two detectors. Detector A works in one of two modes. In stretch mode it measures how long SCL stays low without a break. In idle mode it measures how long both lines stay high while no transfer is in progress. Detector B adds up the clock-low extension time of the local device over a whole transfer. It follows either the master-side or the slave-side extension indication, as the role input selects.

START and STOP framing arrive from the protocol engine as single-cycle strobes. The strobes define when the bus is busy and mark the bounds of each transfer for detector B. Each detector's 12-bit threshold and A's mode bit sit in small configuration registers. These registers accept a write only while the matching detector is disabled. The flags stay set until their clear input is pulsed.

Top module: `smbus_timeout_mon`

## Requirements
- R1: After reset both flags are 0, both thresholds are 0, detector A is in stretch mode (a_idle_mode 0), and the bus is taken as idle.
- R2: With a_idle_mode 0 and a_en_i 1, a_flag_o rises exactly (a_limit+1) x LONG_DIV kernel cycles after SCL goes low and stays low. a_limit is a 12-bit field (0 to 4095).
- R3: In stretch mode, SCL going high before the threshold restarts the measurement from zero.
- R4: With a_idle_mode 1, a_flag_o rises after (a_limit+1) x SHORT_DIV cycles with SCL and SDA both high while the bus is idle. The bus is busy from a START strobe until a STOP strobe. Time while the bus is busy, or while SDA is low, does not count.
- R5: While a_en_i is 0, a_flag_o never becomes set. Dropping a_en_i discards the partial measurement.
- R6: A write to a_limit or a_idle_mode has no effect while a_en_i is 1.
- R7: Detector B adds up, across gaps, the cycles in which the selected extension input is high during a transfer: mst_ext_i when role_master_i is 1, slv_ext_i when it is 0. b_flag_o rises when the sum reaches (b_limit+1) x LONG_DIV.
- R8: The detector B sum clears on every START or STOP strobe, and it does not grow while the bus is idle.
- R9: A write to b_limit has no effect while b_en_i is 1. While b_en_i is 0, b_flag_o never becomes set.
- R10: Each flag is sticky until its clear input is pulsed. One violation raises a flag only once: after a clear during the same violation, the flag stays 0 until the condition ends and a new violation occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| start_stb_i | input | 1 | One-cycle START (or repeated START) strobe |
| stop_stb_i | input | 1 | One-cycle STOP strobe |
| role_master_i | input | 1 | 1 selects mst_ext_i, 0 selects slv_ext_i for detector B |
| mst_ext_i | input | 1 | Local master is extending SCL low |
| slv_ext_i | input | 1 | Local slave is extending SCL low |
| a_en_i | input | 1 | Detector A enable |
| a_wr_i | input | 1 | Write strobe for a_limit and a_idle_mode |
| a_idle_mode_i | input | 1 | Mode value to write: 0 stretch, 1 idle-high |
| a_limit_i | input | CNT_W | Threshold A value to write |
| a_clr_i | input | 1 | Clears a_flag_o |
| b_en_i | input | 1 | Detector B enable |
| b_wr_i | input | 1 | Write strobe for b_limit |
| b_limit_i | input | CNT_W | Threshold B value to write |
| b_clr_i | input | 1 | Clears b_flag_o |
| a_flag_o | output | 1 | Sticky detector A timeout flag |
| b_flag_o | output | 1 | Sticky detector B timeout flag |

## Verification
The hardest case to reach is detector B's sum over a transfer. Extension time arrives in short bursts separated by gaps. The sum must survive every gap and vanish on a repeated START or a STOP. The bench drives on/off burst patterns at the extension inputs. It counts only the cycles in which the selected input was high, and checks that the flag rises at exactly the computed sum. It also breaks a partly built sum with a strobe and then requires a full fresh threshold. Ignored configuration writes leave nothing visible directly, so the bench exposes them by timing the next timeout against the old threshold.

// File: rtl/smbto_pkg.sv
// Shared types for the SMBus timeout monitor.
package smbto_pkg;
    // Prescaler length choice: long period for stretch/extension, short for idle.
    typedef enum logic {
        DIV_LONG  = 1'b0,
        DIV_SHORT = 1'b1
    } div_sel_e;
endpackage

// File: rtl/smbto_scaled_counter.sv
// Prescaled threshold counter.
// Counts kernel cycles while run is high, in units of LONG_DIV or SHORT_DIV
// cycles. Pulses hit_o once, on the cycle the (limit+1)-th unit completes.
// After that it stays quiet until clr. Holding run low freezes progress.
// Assumes SHORT_DIV <= LONG_DIV and both are at least 2.
module smbto_scaled_counter
    import smbto_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int LONG_DIV  = 2048,
    parameter int SHORT_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  div_sel_e         div_sel,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             hit_o
);
    localparam int PRE_W = $clog2(LONG_DIV);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_last;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             wrap;

    // Terminal prescaler value for the selected period.
    always_comb begin
        pre_last = (div_sel == DIV_SHORT) ? PRE_W'(SHORT_DIV - 1) : PRE_W'(LONG_DIV - 1);
        wrap     = (pre_q == pre_last);
        hit_o    = run && !done_q && wrap && (cnt_q == limit);
    end

    // Prescaler, unit counter and fired latch.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (run && !done_q) begin
            if (wrap) begin
                pre_q <= '0;
                if (cnt_q == limit) begin
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smbto_bus_state.sv
// Bus busy tracker: busy from a START strobe until a STOP strobe.
// Assumes the strobes are single-cycle and synchronous to clk.
module smbto_bus_state (
    input  logic clk,
    input  logic rst_n,
    input  logic start_stb,
    input  logic stop_stb,
    output logic busy_o
);
    // Set on START, clear on STOP, START wins if both arrive together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
        end else if (start_stb) begin
            busy_o <= 1'b1;
        end else if (stop_stb) begin
            busy_o <= 1'b0;
        end
    end
endmodule

// File: rtl/smbus_timeout_mon.sv
// SMBus timeout monitor top.
// Detector A: continuous SCL-low time (stretch mode) or idle bus-high time
// (idle mode). Detector B: cumulative local clock-low extension inside one
// transfer. Configuration registers are locked while their detector is
// enabled. Flags are sticky until cleared; a new hit beats a clear.
// Assumes scl_i/sda_i are already synchronized to clk.
module smbus_timeout_mon
    import smbto_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int LONG_DIV  = 2048,
    parameter int SHORT_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             start_stb_i,
    input  logic             stop_stb_i,
    input  logic             role_master_i,
    input  logic             mst_ext_i,
    input  logic             slv_ext_i,
    input  logic             a_en_i,
    input  logic             a_wr_i,
    input  logic             a_idle_mode_i,
    input  logic [CNT_W-1:0] a_limit_i,
    input  logic             a_clr_i,
    input  logic             b_en_i,
    input  logic             b_wr_i,
    input  logic [CNT_W-1:0] b_limit_i,
    input  logic             b_clr_i,
    output logic             a_flag_o,
    output logic             b_flag_o
);
    logic [CNT_W-1:0] a_limit_q;
    logic             a_mode_q;
    logic [CNT_W-1:0] b_limit_q;
    logic             busy_q;
    logic             a_run;
    logic             b_run;
    logic             b_clr_sum;
    logic             a_hit;
    logic             b_hit;
    div_sel_e         a_div;

    // Configuration registers: writes accepted only while detector is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_limit_q <= '0;
            a_mode_q  <= 1'b0;
            b_limit_q <= '0;
        end else begin
            if (a_wr_i && !a_en_i) begin
                a_limit_q <= a_limit_i;
                a_mode_q  <= a_idle_mode_i;
            end
            if (b_wr_i && !b_en_i) begin
                b_limit_q <= b_limit_i;
            end
        end
    end

    smbto_bus_state u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_stb (start_stb_i),
        .stop_stb  (stop_stb_i),
        .busy_o    (busy_q)
    );

    // Monitored conditions for both detectors.
    always_comb begin
        a_div     = a_mode_q ? DIV_SHORT : DIV_LONG;
        a_run     = a_en_i && (a_mode_q ? (!busy_q && scl_i && sda_i) : !scl_i);
        b_run     = b_en_i && busy_q && (role_master_i ? mst_ext_i : slv_ext_i);
        b_clr_sum = start_stb_i || stop_stb_i;
    end

    smbto_scaled_counter #(
        .CNT_W     (CNT_W),
        .LONG_DIV  (LONG_DIV),
        .SHORT_DIV (SHORT_DIV)
    ) u_cnt_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (a_div),
        .run     (a_run),
        .clr     (!a_run),
        .limit   (a_limit_q),
        .hit_o   (a_hit)
    );

    smbto_scaled_counter #(
        .CNT_W     (CNT_W),
        .LONG_DIV  (LONG_DIV),
        .SHORT_DIV (SHORT_DIV)
    ) u_cnt_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (DIV_LONG),
        .run     (b_run),
        .clr     (b_clr_sum),
        .limit   (b_limit_q),
        .hit_o   (b_hit)
    );

    // Sticky flags: set on hit, cleared by pulse, hit has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_flag_o <= 1'b0;
            b_flag_o <= 1'b0;
        end else begin
            if (a_hit) begin
                a_flag_o <= 1'b1;
            end else if (a_clr_i) begin
                a_flag_o <= 1'b0;
            end
            if (b_hit) begin
                b_flag_o <= 1'b1;
            end else if (b_clr_i) begin
                b_flag_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/smbto_checker.sv
// Property checker for smbus_timeout_mon, attached by bind below.
module smbto_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_en_i,
    input logic             b_en_i,
    input logic             a_clr_i,
    input logic             b_clr_i,
    input logic             a_flag_o,
    input logic             b_flag_o,
    input logic             a_hit,
    input logic             b_hit,
    input logic [CNT_W-1:0] a_limit_q,
    input logic             a_mode_q,
    input logic [CNT_W-1:0] b_limit_q,
    input logic             busy_q
);
    AST_A_OFF_NO_SET:   assert property (@(posedge clk) disable iff (!rst_n) !a_en_i |=> !$rose(a_flag_o)); // R5
    AST_A_CFG_LOCKED:   assert property (@(posedge clk) disable iff (!rst_n) a_en_i |=> ($stable(a_limit_q) && $stable(a_mode_q))); // R6
    AST_B_CFG_LOCKED:   assert property (@(posedge clk) disable iff (!rst_n) b_en_i |=> $stable(b_limit_q)); // R9
    AST_B_OFF_NO_SET:   assert property (@(posedge clk) disable iff (!rst_n) !b_en_i |=> !$rose(b_flag_o)); // R9
    AST_B_IDLE_NO_SET:  assert property (@(posedge clk) disable iff (!rst_n) !busy_q |=> !$rose(b_flag_o)); // R8
    AST_A_FLAG_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) (a_flag_o && !a_clr_i) |=> a_flag_o); // R10
    AST_B_FLAG_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) (b_flag_o && !b_clr_i) |=> b_flag_o); // R10
    AST_A_CLEAR_WORKS:  assert property (@(posedge clk) disable iff (!rst_n) (a_clr_i && !a_hit) |=> !a_flag_o); // R10
    AST_B_CLEAR_WORKS:  assert property (@(posedge clk) disable iff (!rst_n) (b_clr_i && !b_hit) |=> !b_flag_o); // R10
endmodule

bind smbus_timeout_mon smbto_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_en_i    (a_en_i),
    .b_en_i    (b_en_i),
    .a_clr_i   (a_clr_i),
    .b_clr_i   (b_clr_i),
    .a_flag_o  (a_flag_o),
    .b_flag_o  (b_flag_o),
    .a_hit     (a_hit),
    .b_hit     (b_hit),
    .a_limit_q (a_limit_q),
    .a_mode_q  (a_mode_q),
    .b_limit_q (b_limit_q),
    .busy_q    (busy_q)
);

// File: tb/sim_smbus_timeout_mon.sv
// Self-checking bench: sweeps small thresholds with shortened prescalers.
module sim_smbus_timeout_mon;
    localparam int CNT_W = 12;
    localparam int LDIV  = 8;
    localparam int SDIV  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, start_stb = 1'b0, stop_stb = 1'b0;
    logic role_m = 1'b1, mst_ext = 1'b0, slv_ext = 1'b0;
    logic a_en = 1'b0, a_wr = 1'b0, a_mode = 1'b0, a_clr = 1'b0;
    logic b_en = 1'b0, b_wr = 1'b0, b_clr = 1'b0;
    logic [CNT_W-1:0] a_lim = '0, b_lim = '0;
    logic a_flag, b_flag;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    smbus_timeout_mon #(.CNT_W(CNT_W), .LONG_DIV(LDIV), .SHORT_DIV(SDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .start_stb_i(start_stb), .stop_stb_i(stop_stb),
        .role_master_i(role_m), .mst_ext_i(mst_ext), .slv_ext_i(slv_ext),
        .a_en_i(a_en), .a_wr_i(a_wr), .a_idle_mode_i(a_mode), .a_limit_i(a_lim),
        .a_clr_i(a_clr), .b_en_i(b_en), .b_wr_i(b_wr), .b_limit_i(b_lim),
        .b_clr_i(b_clr), .a_flag_o(a_flag), .b_flag_o(b_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Disable A, write config, clear flag.
    task automatic set_a(input int n, input bit mode);
        @(negedge clk);
        a_en = 0; a_wr = 1; a_lim = CNT_W'(n); a_mode = mode; a_clr = 1;
        @(negedge clk);
        a_wr = 0; a_clr = 0;
    endtask

    task automatic set_b(input int n);
        @(negedge clk);
        b_en = 0; b_wr = 1; b_lim = CNT_W'(n); b_clr = 1;
        @(negedge clk);
        b_wr = 0; b_clr = 0;
    endtask

    // Count cycles until a_flag rises; lim+1 if it never does.
    task automatic wait_a(output int n, input int lim);
        n = 0;
        while (!a_flag && n <= lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic strobe(input bit st);
        @(negedge clk);
        if (st) start_stb = 1; else stop_stb = 1;
        @(negedge clk);
        start_stb = 0; stop_stb = 0;
    endtask

    // Drive an on/off burst pattern on one extension input; count on-cycles
    // until b_flag rises. Returns -1 if no flag within lim cycles.
    task automatic burst_b(input bit drive_mst, input int on, input int off,
                           input int lim, output int cnt);
        int cyc = 0;
        cnt = 0;
        while (!b_flag && cyc < lim) begin
            bit e = ((cyc % (on + off)) < on);
            if (drive_mst) mst_ext = e; else slv_ext = e;
            @(negedge clk);
            if (e) cnt++;
            cyc++;
        end
        mst_ext = 0; slv_ext = 0;
        if (!b_flag) cnt = -1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(a_flag == 0, "R1 a_flag reset", a_flag, 0);
        chk(b_flag == 0, "R1 b_flag reset", b_flag, 0);
        // R1: default threshold 0, stretch mode -> LDIV cycles
        scl = 0; a_en = 1;
        wait_a(n, 1000);
        chk(n == LDIV, "R1 default threshold", n, LDIV);
        scl = 1;

        // R2: sweep of thresholds in stretch mode
        for (int k = 0; k < 7; k++) begin
            set_a(k, 0);
            scl = 0; a_en = 1;
            wait_a(n, 1000);
            chk(n == (k + 1) * LDIV, "R2 stretch threshold", n, (k + 1) * LDIV);
            scl = 1;
        end
        set_a(4095, 0);
        scl = 0; a_en = 1;
        wait_a(n, 40000);
        chk(n == 4096 * LDIV, "R2 max field", n, 4096 * LDIV);
        scl = 1;

        // R3: restart on SCL high
        set_a(2, 0);
        scl = 0; a_en = 1;
        repeat (20) @(negedge clk);
        chk(a_flag == 0, "R3 before restart", a_flag, 0);
        scl = 1;
        @(negedge clk);
        scl = 0;
        wait_a(n, 1000);
        chk(n == 3 * LDIV, "R3 restart", n, 3 * LDIV);

        // R10: one event per violation, then sticky
        @(negedge clk); a_clr = 1;
        @(negedge clk); a_clr = 0;
        chk(a_flag == 0, "R10 clear", a_flag, 0);
        repeat (40) @(negedge clk);
        chk(a_flag == 0, "R10 no refire same violation", a_flag, 0);
        scl = 1;
        @(negedge clk);
        scl = 0;
        wait_a(n, 1000);
        chk(n == 3 * LDIV, "R10 new violation", n, 3 * LDIV);
        scl = 1;
        repeat (30) @(negedge clk);
        chk(a_flag == 1, "R10 sticky", a_flag, 1);

        // R5: disabled detector never flags; disable drops progress
        set_a(2, 0);
        scl = 0;
        repeat (100) @(negedge clk);
        chk(a_flag == 0, "R5 disabled", a_flag, 0);
        a_en = 1;
        repeat (20) @(negedge clk);
        a_en = 0;
        @(negedge clk);
        a_en = 1;
        wait_a(n, 1000);
        chk(n == 3 * LDIV, "R5 progress dropped", n, 3 * LDIV);
        scl = 1;

        // R6: writes ignored while enabled
        set_a(2, 0);
        a_en = 1;
        @(negedge clk);
        a_wr = 1; a_lim = 0; a_mode = 1;
        @(negedge clk);
        a_wr = 0;
        scl = 0;
        wait_a(n, 1000);
        chk(n == 3 * LDIV, "R6 locked config", n, 3 * LDIV);
        scl = 1;

        // R4: idle-high sweep
        for (int k = 0; k < 7; k++) begin
            set_a(k, 1);
            scl = 1; sda = 1; a_en = 1;
            wait_a(n, 1000);
            chk(n == (k + 1) * SDIV, "R4 idle threshold", n, (k + 1) * SDIV);
        end
        set_a(3, 1);
        strobe(1);
        a_en = 1;
        wait_a(n, 100);
        chk(n == 101, "R4 busy bus not idle", n, 101);
        a_en = 0;
        strobe(0);
        sda = 0; a_en = 1;
        wait_a(n, 100);
        chk(n == 101, "R4 SDA low not idle", n, 101);
        a_en = 0; sda = 1;

        // R7: cumulative extension, master role, sweep
        for (int k = 0; k < 5; k++) begin
            set_b(k);
            role_m = 1; b_en = 1;
            strobe(1);
            burst_b(1, 3, 2, 2000, n);
            chk(n == (k + 1) * LDIV, "R7 master cumulative", n, (k + 1) * LDIV);
            strobe(0);
        end
        // R7: slave role ignores master input, counts slave input
        set_b(1);
        role_m = 0; b_en = 1;
        strobe(1);
        burst_b(1, 5, 1, 200, n);
        chk(n == -1, "R7 slave ignores master ext", n, -1);
        burst_b(0, 5, 3, 2000, n);
        chk(n == 2 * LDIV, "R7 slave cumulative", n, 2 * LDIV);
        strobe(0);

        // R8: repeated START clears the sum
        set_b(2);
        role_m = 1; b_en = 1;
        strobe(1);
        burst_b(1, 20, 1, 20, n);
        chk(b_flag == 0, "R8 partial sum", b_flag, 0);
        strobe(1);
        burst_b(1, 4, 4, 2000, n);
        chk(n == 3 * LDIV, "R8 cleared by START", n, 3 * LDIV);
        // R8: STOP clears the sum
        set_b(2);
        b_en = 1;
        strobe(1);
        burst_b(1, 20, 1, 20, n);
        strobe(0);
        strobe(1);
        burst_b(1, 7, 2, 2000, n);
        chk(n == 3 * LDIV, "R8 cleared by STOP", n, 3 * LDIV);
        strobe(0);
        // R8: idle bus does not accumulate
        set_b(0);
        b_en = 1;
        burst_b(1, 10, 0, 100, n);
        chk(n == -1, "R8 idle no count", n, -1);

        // R9: write ignored while enabled; disabled never flags
        set_b(1);
        b_en = 1;
        @(negedge clk); b_wr = 1; b_lim = 0;
        @(negedge clk); b_wr = 0;
        strobe(1);
        burst_b(1, 6, 2, 2000, n);
        chk(n == 2 * LDIV, "R9 locked b_limit", n, 2 * LDIV);
        strobe(0);
        set_b(0);
        strobe(1);
        burst_b(1, 10, 0, 100, n);
        chk(n == -1, "R9 disabled", n, -1);
        strobe(0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule